// File: doc/BRIEF.md
# Conditional Return Stack Unit

This block keeps the return addresses of a small processor in a hardware last-in-first-out stack. It evaluates each decoded return instruction against the carry, zero and sign flags. A call pushes its return address. A return whose condition holds pops the top entry and offers it as the next instruction pointer, with a take indication. A return whose condition fails leaves the stack and the instruction pointer alone, so fetch simply moves on to the next instruction.

The outputs are combinational from the current stack top, the decoded operation and the flags. The stack itself changes on the next rising clock edge. When the stack is already full, a push overwrites the oldest entry, because the pointer wraps. A return from interrupt always pops and also raises a strobe, so that the interrupt controller can clear its in-service state.

Overflow and underflow are sticky status bits that only reset clears.

Top module: `ret_stack_unit`

## Requirements
- R1: Operation code 1 (plain return) always requests a pop. On a non-empty stack, take_o is 1 and next_ip_o equals the most recently pushed live address.
- R2: Code 2 (return if carry) requests a pop only when carry_i is 1. Code 3 (return if no carry) requests a pop only when carry_i is 0.
- R3: Code 4 (return if zero) requests a pop only when zero_i is 1. Code 5 (return if not zero) requests a pop only when zero_i is 0.
- R4: Code 6 (return if sign) requests a pop only when sign_i is 1.
- R5: When a return's condition is false, or when the code is 0 (no operation), take_o is 0 and the stack is left unchanged. A later plain return therefore yields the same address.
- R6: Code 7 (return from interrupt) always requests a pop. reti_o is 1 in exactly the cycles in which code 7 is presented.
- R7: A push stores push_addr_i. Pops return the stored addresses in reverse order of pushing.
- R8: The stack holds 8 entries. A push while 8 entries are live sets overflow_o from the next cycle and overwrites the oldest entry. The live count stays at 8.
- R9: A pop request on an empty stack gives take_o 0 and sets underflow_o from the next cycle. The stack stays empty.
- R10: empty_o is 1 exactly when no entry is live.
- R11: A push in the same cycle as a taken pop replaces the top entry, and the live count is unchanged.
- R12: After reset, empty_o is 1, overflow_o and underflow_o are 0, and take_o is 0 while no operation is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push request (call) |
| push_addr_i | input | 16 | Return address to push |
| ret_op_i | input | 3 | Decoded return: 0 none, 1 RET, 2 C, 3 NC, 4 Z, 5 NZ, 6 S, 7 RETI |
| carry_i | input | 1 | Carry flag |
| zero_i | input | 1 | Zero flag (accumulator equals zero) |
| sign_i | input | 1 | Sign flag |
| next_ip_o | output | 16 | Popped address, valid when take_o is 1 |
| take_o | output | 1 | Load next_ip_o into the instruction pointer |
| empty_o | output | 1 | No live entries |
| overflow_o | output | 1 | Sticky: a push found the stack full |
| underflow_o | output | 1 | Sticky: a pop request found the stack empty |
| reti_o | output | 1 | Return-from-interrupt strobe |

## Verification
The embedded properties check the following every cycle:
- the flag gating of each conditional return code;
- that take_o never rises on an empty stack;
- that a cycle with neither push nor pop holds the pointer and count;
- that the count steps by one on a lone push or pop;
- the stickiness and setting of both error flags.

Only the bench scenarios can show that the address offered on a taken return is the right one. This covers LIFO ordering, the overwrite of the oldest entry after a wrap, and a same-cycle push replacing the top. The bench compares every cycle against a reference stack model while it sweeps all eight codes across all flag combinations.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RET  = 3'd1,
    OP_RC   = 3'd2,
    OP_RNC  = 3'd3,
    OP_RZ   = 3'd4,
    OP_RNZ  = 3'd5,
    OP_RS   = 3'd6,
    OP_RETI = 3'd7
  } ret_op_e;
endpackage

// File: rtl/ret_cond_eval.sv
module ret_cond_eval
  import ret_stack_pkg::*;
(
  input  ret_op_e op_i,
  input  logic    carry_i,
  input  logic    zero_i,
  input  logic    sign_i,
  output logic    pop_req_o,
  output logic    reti_o
);
  always_comb begin
    unique case (op_i)
      OP_RET, OP_RETI: pop_req_o = 1'b1;
      OP_RC:           pop_req_o = carry_i;
      OP_RNC:          pop_req_o = ~carry_i;
      OP_RZ:           pop_req_o = zero_i;
      OP_RNZ:          pop_req_o = ~zero_i;
      OP_RS:           pop_req_o = sign_i;
      default:         pop_req_o = 1'b0;
    endcase
  end
  assign reti_o = (op_i == OP_RETI);
endmodule

// File: rtl/ret_lifo.sv
module ret_lifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_req_i,
  output logic             pop_ok_o,
  output logic [WIDTH-1:0] top_o,
  output logic             empty_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] sp_q;   // next free slot, wraps
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] top_idx, wr_idx;
  logic             ovf_q, unf_q;

  assign empty_o  = (cnt_q == '0);
  assign pop_ok_o = pop_req_i & ~empty_o;
  assign top_idx  = sp_q - 1'b1;
  assign wr_idx   = pop_ok_o ? top_idx : sp_q;
  assign top_o    = slot_q[top_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (push_i && wr_idx == PTR_W'(g)) slot_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (pop_req_i && empty_o) unf_q <= 1'b1;
      if (push_i && !pop_ok_o) begin
        sp_q <= sp_q + 1'b1;
        if (cnt_q == FULL_CNT) ovf_q <= 1'b1;
        else                   cnt_q <= cnt_q + 1'b1;
      end else if (pop_ok_o && !push_i) begin
        sp_q  <= top_idx;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_ok_o) |=> ($stable(sp_q) && $stable(cnt_q)));
  p_pop_dec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_ok_o && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_push_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_ok_o && cnt_q != FULL_CNT) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_ovf_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_ok_o && cnt_q == FULL_CNT) |=> (overflow_o && cnt_q == FULL_CNT));
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  p_unf_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && empty_o) |=> underflow_o);
  p_unf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  p_swap_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_ok_o) |=> $stable(cnt_q));
endmodule

// File: rtl/ret_stack_unit.sv
module ret_stack_unit
  import ret_stack_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [2:0]        ret_op_i,
  input  logic              carry_i,
  input  logic              zero_i,
  input  logic              sign_i,
  output logic [ADDR_W-1:0] next_ip_o,
  output logic              take_o,
  output logic              empty_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic              reti_o
);
  ret_op_e op;
  logic    pop_req;

  assign op = ret_op_e'(ret_op_i);

  ret_cond_eval u_cond (
    .op_i      (op),
    .carry_i   (carry_i),
    .zero_i    (zero_i),
    .sign_i    (sign_i),
    .pop_req_o (pop_req),
    .reti_o    (reti_o)
  );

  ret_lifo #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) u_lifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_data_i (push_addr_i),
    .pop_req_i   (pop_req),
    .pop_ok_o    (take_o),
    .top_o       (next_ip_o),
    .empty_o     (empty_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  p_no_take_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !take_o);
  p_carry_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ret_op_i == 3'd2 && !carry_i) || (ret_op_i == 3'd3 && carry_i)) |-> !take_o);
  p_zero_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ret_op_i == 3'd4 && !zero_i) || (ret_op_i == 3'd5 && zero_i)) |-> !take_o);
  p_sign_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_op_i == 3'd6 && !sign_i) |-> !take_o);
  p_none_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_op_i == 3'd0) |-> !take_o);
  p_reti_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_o && !empty_o) |-> take_o);
  p_plain_take_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_op_i == 3'd1 && !empty_o) |-> take_o);
endmodule

// File: tb/ret_stack_unit_tb.sv
module ret_stack_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push;
  logic [15:0] push_addr;
  logic [2:0]  op;
  logic        c, z, s;
  logic [15:0] next_ip;
  logic        take, empty, ovf, unf, reti;

  int total = 0;
  int bad = 0;

  logic [15:0] mdl [8];
  int  mcnt, msp;
  bit  movf, munf;

  always #5 clk = ~clk;

  ret_stack_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_addr_i(push_addr),
    .ret_op_i(op), .carry_i(c), .zero_i(z), .sign_i(s),
    .next_ip_o(next_ip), .take_o(take), .empty_o(empty),
    .overflow_o(ovf), .underflow_o(unf), .reti_o(reti)
  );

  function automatic bit want_pop(input logic [2:0] o, input logic fc, fz, fs);
    case (o)
      3'd1, 3'd7: return 1'b1;
      3'd2: return fc;
      3'd3: return !fc;
      3'd4: return fz;
      3'd5: return !fz;
      3'd6: return fs;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd1: return "R1";
      3'd2, 3'd3: return "R2";
      3'd4, 3'd5: return "R3";
      3'd6: return "R4";
      3'd7: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; push = 0; push_addr = 0; op = 0; c = 0; z = 0; s = 0;
    mcnt = 0; msp = 0; movf = 0; munf = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // one cycle: drive at negedge, check outputs, update model at posedge
  task automatic step(input bit p, input logic [15:0] a, input logic [2:0] o,
                      input logic fc, fz, fs);
    bit w, tk;
    @(negedge clk);
    push = p; push_addr = a; op = o; c = fc; z = fz; s = fs;
    #1;
    w  = want_pop(o, fc, fz, fs);
    tk = w && (mcnt > 0);
    chk(tag_of(o), take, tk);
    if (tk) chk("R7", next_ip, mdl[(msp + 7) % 8]);
    chk("R6", reti, o == 3'd7);
    chk("R10", empty, mcnt == 0);
    chk("R8", ovf, movf);
    chk("R9", unf, munf);
    @(posedge clk);
    if (w && mcnt == 0) munf = 1;
    if (p && tk) mdl[(msp + 7) % 8] = a;              // R11 replace top
    else if (p) begin
      mdl[msp] = a; msp = (msp + 1) % 8;
      if (mcnt == 8) movf = 1; else mcnt++;
    end else if (tk) begin
      msp = (msp + 7) % 8; mcnt--;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R12", empty, 1); chk("R12", ovf, 0); chk("R12", unf, 0); chk("R12", take, 0);

    // R5: false condition on empty stack does not flag underflow
    step(0, 0, 3'd2, 0, 0, 0);
    step(0, 0, 3'd0, 0, 0, 0);
    // R9: real pop request on empty
    step(0, 0, 3'd2, 1, 0, 0);
    step(0, 0, 3'd0, 0, 0, 0);

    // sweep all codes across all flag combinations
    for (int o = 0; o < 8; o++) begin
      for (int f = 0; f < 8; f++) begin
        while (mcnt < 3) step(1, 16'h1000 + 16'(o * 64 + f * 4 + mcnt), 3'd0, 0, 0, 0);
        step(0, 0, 3'(o), f[0], f[1], f[2]);
        step(0, 0, 3'd1, 0, 0, 0);    // R5: plain return shows what is on top
      end
    end

    // R7 LIFO order
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 16'hA000 + 16'(i * 3), 3'd0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 3'd1, 0, 0, 0);
    step(0, 0, 3'd0, 0, 0, 0);

    // R8 overflow and wrap
    for (int i = 0; i < 10; i++) step(1, 16'hB000 + 16'(i), 3'd0, 0, 0, 0);
    for (int i = 0; i < 9; i++) step(0, 0, 3'd7, 0, 0, 0);
    step(0, 0, 3'd0, 0, 0, 0);

    // R11 push with taken pop
    do_reset();
    step(1, 16'h0111, 3'd0, 0, 0, 0);
    step(1, 16'h0222, 3'd0, 0, 0, 0);
    step(1, 16'h0333, 3'd4, 0, 1, 0);
    step(1, 16'h0444, 3'd4, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 3'd1, 0, 0, 0);
    step(0, 0, 3'd0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule